// File: doc/BRIEF.md
# Sub-group Cross-Lane Collective Unit

This unit moves and combines values across the lanes of one sub-group entirely in registers. It does not touch memory and does not need a barrier. A command carries an opcode, one data word per lane packed into a single vector, one index field per lane, and a reduction operator select. The unit accepts a command on a valid/ready handshake. It returns the full lane vector together with a one-cycle done pulse.

The unit has two data-movement families. The first is a lane crossbar, used for indexed shuffle, XOR-distance shuffle and broadcast; it produces its result one cycle after the command is accepted. The second is a pairwise reduction tree that supports sum, unsigned maximum and logical AND. The tree has a pipeline register after every second level, so an 8-lane reduction is ready two cycles after issue. The unit holds one command at a time. While a reduction is in flight, the ready signal stays low and any offered command is ignored.

Top module: `xlane_unit`

## Requirements
- R1: While reset is asserted, and right after it is released, cmdReady is 1, resDone is 0 and resData is all zeros.
- R2: With opcode 0 (indexed shuffle), output lane i holds input lane (idx_i mod LANES). Data lane i sits in bits [i*DATA_W +: DATA_W] and index field i in bits [i*IDX_W +: IDX_W]. An index above LANES-1 wraps.
- R3: With opcode 1 (XOR shuffle), output lane i holds input lane i XOR (idx_i mod LANES). For example, an index of 4 on every lane of 8 swaps lane 0 with lane 4 and lane 1 with lane 5.
- R4: With opcode 2 (broadcast), every output lane holds input lane (idx_0 mod LANES), so only lane 0's index field is used.
- R5: For opcodes 0, 1 and 2, resDone and the new resData appear one cycle after the accepting clock edge, and cmdReady stays 1.
- R6: With opcode 3 and redSel 0 or 3, lane 0 of the result is the sum of all lanes modulo 2^DATA_W.
- R7: With opcode 3 and redSel 1, lane 0 is the unsigned maximum of all lanes.
- R8: With opcode 3 and redSel 2, lane 0 is 1 when every lane is nonzero and 0 otherwise.
- R9: After a reduction, lanes 1 to LANES-1 of resData are zero.
- R10: A reduction completes ceil(log2(LANES)/2) cycles after acceptance, which is 2 cycles for 8 lanes. cmdReady is 0 in the cycles between, and a command offered then is not accepted.
- R11: resDone is high for exactly one cycle per accepted command. resData keeps its value until the next result is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Unit can take a command |
| cmdOp | input | 2 | 0 indexed shuffle, 1 XOR shuffle, 2 broadcast, 3 reduce |
| redSel | input | 2 | 0 sum, 1 max, 2 logical AND, 3 sum |
| laneData | input | LANES*DATA_W | Lane-packed input values |
| laneIdx | input | LANES*IDX_W | Lane-packed index fields |
| resData | output | LANES*DATA_W | Lane-packed result |
| resDone | output | 1 | One-cycle pulse when resData is new |

## Verification
A fault in the crossbar select would put the wrong lane's word into resData on the cycle right after acceptance. A wrong reduction operator or a bad tree stage would corrupt lane 0 two cycles after issue. If the in-flight counter of the control were wrong, the done pulse would come early, come late or be missing. Ready would also fail to drop, or an offered command would slip in during a reduction, and the result data would change in the cycle after the done pulse.

// File: rtl/xlane_pkg.sv
package xlane_pkg;

  typedef enum logic [1:0] {
    OP_PICK   = 2'd0,
    OP_XOR    = 2'd1,
    OP_BCAST  = 2'd2,
    OP_REDUCE = 2'd3
  } xl_op_e;

  typedef enum logic [1:0] {
    RD_SUM  = 2'd0,
    RD_MAX  = 2'd1,
    RD_ALL  = 2'd2,
    RD_SUMB = 2'd3
  } xl_red_e;

  typedef struct packed {
    logic takeCmd;
    logic loadMove;
    logic loadTree;
  } xl_strobe_t;

endpackage

// File: rtl/xlane_ctrl.sv
module xlane_ctrl
  import xlane_pkg::*;
#(
  parameter int RED_LAT = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       cmdIsReduce,
  output logic       cmdReady,
  output logic       resDone,
  output xl_strobe_t strobe
);

  localparam int CW = $clog2(RED_LAT + 1);

  logic          busy;
  logic [CW-1:0] cnt;
  logic          doneQ;
  logic          accept;
  logic          treeLast;

  assign cmdReady = !busy;
  assign accept   = cmdValid && !busy;
  assign treeLast = busy && (cnt == CW'(1));
  assign resDone  = doneQ;

  always_comb begin
    strobe.takeCmd  = accept;
    strobe.loadMove = accept && !cmdIsReduce;
    strobe.loadTree = treeLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy  <= 1'b0;
      cnt   <= '0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= (accept && !cmdIsReduce) || treeLast;
      if (accept && cmdIsReduce) begin
        busy <= 1'b1;
        cnt  <= CW'(RED_LAT - 1);
      end else if (busy) begin
        cnt <= cnt - CW'(1);
        if (treeLast) busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/xlane_tree.sv
module xlane_tree #(
  parameter int LANES  = 8,
  parameter int DATA_W = 16
) (
  input  logic                      clk,
  input  logic [LANES*DATA_W-1:0]   dataIn,
  input  logic [1:0]                selNow,
  input  logic [1:0]                selHeld,
  output logic [DATA_W-1:0]         treeOut
);

  localparam int LV = $clog2(LANES);

  logic [DATA_W-1:0] vNode [LV+1][LANES];
  logic [DATA_W-1:0] rNode [LV+1][LANES];

  function automatic logic [DATA_W-1:0] combine(
    input logic [1:0]        sel,
    input logic [DATA_W-1:0] a,
    input logic [DATA_W-1:0] b
  );
    logic [DATA_W-1:0] r;
    case (sel)
      2'd1:    r = (a > b) ? a : b;
      2'd2:    r = {{(DATA_W-1){1'b0}}, ((a != '0) && (b != '0))};
      default: r = a + b;
    endcase
    return r;
  endfunction

  for (genvar j = 0; j < LANES; j++) begin : g_leaf
    assign vNode[0][j] = dataIn[j*DATA_W +: DATA_W];
  end

  for (genvar k = 1; k <= LV; k++) begin : g_lvl
    for (genvar j = 0; j < LANES; j++) begin : g_node
      if (j < (LANES >> k)) begin : g_live
        logic [DATA_W-1:0] lhs, rhs;
        if (((k - 1) >= 2) && (((k - 1) % 2) == 0)) begin : g_fromReg
          assign lhs = rNode[k-1][2*j];
          assign rhs = rNode[k-1][2*j+1];
        end else begin : g_fromComb
          assign lhs = vNode[k-1][2*j];
          assign rhs = vNode[k-1][2*j+1];
        end
        if (k <= 2) begin : g_selNow
          assign vNode[k][j] = combine(selNow, lhs, rhs);
        end else begin : g_selHeld
          assign vNode[k][j] = combine(selHeld, lhs, rhs);
        end
      end else begin : g_dead
        assign vNode[k][j] = '0;
      end
    end
  end

  for (genvar k = 0; k <= LV; k++) begin : g_stage
    for (genvar j = 0; j < LANES; j++) begin : g_reg
      if ((k >= 2) && ((k % 2) == 0) && (k < LV) && (j < (LANES >> k))) begin : g_pipe
        always_ff @(posedge clk) rNode[k][j] <= vNode[k][j];
      end else begin : g_tie
        always_ff @(posedge clk) rNode[k][j] <= '0;
      end
    end
  end

  assign treeOut = vNode[LV][0];

endmodule

// File: rtl/xlane_path.sv
module xlane_path
  import xlane_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  xl_strobe_t              strobe,
  input  logic [1:0]              cmdOp,
  input  logic [1:0]              redSel,
  input  logic [LANES*DATA_W-1:0] laneData,
  input  logic [LANES*IDX_W-1:0]  laneIdx,
  output logic [LANES*DATA_W-1:0] resData
);

  localparam int IW = $clog2(LANES);

  logic [DATA_W-1:0]       dataArr [LANES];
  logic [LANES*DATA_W-1:0] moved;
  logic [DATA_W-1:0]       treeOut;
  logic [1:0]              selHeld;
  logic [LANES*DATA_W-1:0] resReg;
  logic [IW-1:0]           bcastSrc;

  assign bcastSrc = laneIdx[IW-1:0];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [IW-1:0] own;
    logic [IW-1:0] src;
    assign dataArr[i] = laneData[i*DATA_W +: DATA_W];
    assign own = laneIdx[i*IDX_W +: IW];
    always_comb begin
      case (cmdOp)
        OP_XOR:   src = IW'(i) ^ own;
        OP_BCAST: src = bcastSrc;
        default:  src = own;
      endcase
    end
    assign moved[i*DATA_W +: DATA_W] = dataArr[src];
  end

  always_ff @(posedge clk) begin
    if (!rstN) selHeld <= 2'd0;
    else if (strobe.takeCmd) selHeld <= redSel;
  end

  xlane_tree #(.LANES(LANES), .DATA_W(DATA_W)) tree (
    .clk     (clk),
    .dataIn  (laneData),
    .selNow  (redSel),
    .selHeld (selHeld),
    .treeOut (treeOut)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resReg <= '0;
    end else if (strobe.loadMove) begin
      resReg <= moved;
    end else if (strobe.loadTree) begin
      resReg <= '0;
      resReg[DATA_W-1:0] <= treeOut;
    end
  end

  assign resData = resReg;

endmodule

// File: rtl/xlane_unit.sv
module xlane_unit
  import xlane_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cmdValid,
  output logic                    cmdReady,
  input  logic [1:0]              cmdOp,
  input  logic [1:0]              redSel,
  input  logic [LANES*DATA_W-1:0] laneData,
  input  logic [LANES*IDX_W-1:0]  laneIdx,
  output logic [LANES*DATA_W-1:0] resData,
  output logic                    resDone
);

  localparam int LV      = $clog2(LANES);
  localparam int RED_LAT = (LV + 1) / 2;

  xl_strobe_t strobe;
  logic       cmdIsReduce;

  assign cmdIsReduce = (cmdOp == OP_REDUCE);

  xlane_ctrl #(.RED_LAT(RED_LAT)) ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cmdValid    (cmdValid),
    .cmdIsReduce (cmdIsReduce),
    .cmdReady    (cmdReady),
    .resDone     (resDone),
    .strobe      (strobe)
  );

  xlane_path #(.LANES(LANES), .DATA_W(DATA_W), .IDX_W(IDX_W)) path (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cmdOp    (cmdOp),
    .redSel   (redSel),
    .laneData (laneData),
    .laneIdx  (laneIdx),
    .resData  (resData)
  );

endmodule

// File: rtl/xlane_chk.sv
module xlane_chk #(
  parameter int LANES  = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    cmdValid,
  input logic                    cmdReady,
  input logic [1:0]              cmdOp,
  input logic [LANES*DATA_W-1:0] resData,
  input logic                    resDone
);

  logic taken;
  logic lastWasReduce;

  assign taken = cmdValid && cmdReady;

  always_ff @(posedge clk) begin
    if (!rstN) lastWasReduce <= 1'b0;
    else if (taken) lastWasReduce <= (cmdOp == 2'd3);
  end

  function automatic logic allSame(input logic [LANES*DATA_W-1:0] v);
    logic same;
    same = 1'b1;
    for (int i = 1; i < LANES; i++)
      if (v[i*DATA_W +: DATA_W] != v[DATA_W-1:0]) same = 1'b0;
    return same;
  endfunction

  // R5
  move_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (taken && cmdOp != 2'd3) |=> (resDone && cmdReady));

  // R10
  tree_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (taken && cmdOp == 2'd3) |=> (!resDone && !cmdReady));

  // R9
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resDone && lastWasReduce) |-> (resData[LANES*DATA_W-1:DATA_W] == '0));

  // R4
  bcast_same_chk: assert property (@(posedge clk) disable iff (!rstN)
    (taken && cmdOp == 2'd2) |=> allSame(resData));

  // R11
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resDone |-> $stable(resData));

endmodule

bind xlane_unit xlane_chk #(.LANES(LANES), .DATA_W(DATA_W), .IDX_W(IDX_W)) chk (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .cmdReady (cmdReady),
  .cmdOp    (cmdOp),
  .resData  (resData),
  .resDone  (resDone)
);

// File: tb/xlane_unit_test.sv
module xlane_unit_test;

  localparam int N     = 8;
  localparam int DW    = 16;
  localparam int IW    = 4;
  localparam int CLK_P = 10;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            cmdValid = 1'b0;
  logic            cmdReady;
  logic [1:0]      cmdOp = 2'd0;
  logic [1:0]      redSel = 2'd0;
  logic [N*DW-1:0] laneData = '0;
  logic [N*IW-1:0] laneIdx = '0;
  logic [N*DW-1:0] resData;
  logic            resDone;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  xlane_unit #(.LANES(N), .DATA_W(DW), .IDX_W(IW)) uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .redSel(redSel), .laneData(laneData), .laneIdx(laneIdx),
    .resData(resData), .resDone(resDone)
  );

  task automatic chk(input string tag, input logic [N*DW-1:0] act, input logic [N*DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [N*DW-1:0] expMove(input logic [1:0] op, input logic [N*DW-1:0] d,
                                              input logic [N*IW-1:0] ix);
    logic [N*DW-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++) begin
      int own;
      int s;
      own = int'(ix[i*IW +: IW]) % N;
      if (op == 2'd1)      s = i ^ own;
      else if (op == 2'd2) s = int'(ix[IW-1:0]) % N;
      else                 s = own;
      r[i*DW +: DW] = d[s*DW +: DW];
    end
    return r;
  endfunction

  function automatic logic [N*DW-1:0] expRed(input logic [1:0] sel, input logic [N*DW-1:0] d);
    logic [DW-1:0] acc;
    logic [N*DW-1:0] r;
    if (sel == 2'd1) acc = '0;
    else if (sel == 2'd2) acc = 1;
    else acc = '0;
    for (int i = 0; i < N; i++) begin
      logic [DW-1:0] v;
      v = d[i*DW +: DW];
      if (sel == 2'd1) begin
        if (v > acc) acc = v;
      end else if (sel == 2'd2) begin
        if (v == '0) acc = '0;
      end else begin
        acc = acc + v;
      end
    end
    r = '0;
    r[DW-1:0] = acc;
    return r;
  endfunction

  function automatic string tagOf(input logic [1:0] op, input logic [1:0] sel);
    if (op == 2'd0) return "R2";
    if (op == 2'd1) return "R3";
    if (op == 2'd2) return "R4";
    if (sel == 2'd1) return "R7";
    if (sel == 2'd2) return "R8";
    return "R6";
  endfunction

  // Issue one command at a negedge and check its result at the matching negedge.
  task automatic runCmd(input logic [1:0] op, input logic [1:0] sel, input logic [N*DW-1:0] d,
                        input logic [N*IW-1:0] ix, input bit poke);
    logic [N*DW-1:0] exp;
    @(negedge clk);
    chk("R10 ready before issue", {{(N*DW-1){1'b0}}, cmdReady}, 1);
    cmdOp = op; redSel = sel; laneData = d; laneIdx = ix; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    if (op != 2'd3) begin
      exp = expMove(op, d, ix);
      chk({tagOf(op, sel), " data"}, resData, exp);
      chk("R5 done after move", {{(N*DW-1){1'b0}}, resDone}, 1);
      chk("R5 ready kept", {{(N*DW-1){1'b0}}, cmdReady}, 1);
    end else begin
      exp = expRed(sel, d);
      chk("R10 no early done", {{(N*DW-1){1'b0}}, resDone}, 0);
      chk("R10 ready low", {{(N*DW-1){1'b0}}, cmdReady}, 0);
      if (poke) begin
        cmdOp = 2'd2; laneData = ~d; laneIdx = '0; cmdValid = 1'b1;
      end
      @(negedge clk);
      cmdValid = 1'b0;
      chk({tagOf(op, sel), " R9 data"}, resData, exp);
      chk("R10 done at lat", {{(N*DW-1){1'b0}}, resDone}, 1);
      if (poke) begin
        @(negedge clk);
        chk("R11 done single", {{(N*DW-1){1'b0}}, resDone}, 0);
        chk("R11 R10 held", resData, exp);
      end
    end
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL R10 watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    logic [N*DW-1:0] d;
    logic [N*IW-1:0] ix;
    void'($urandom(32'd715));
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 ready in reset", {{(N*DW-1){1'b0}}, cmdReady}, 1);
    chk("R1 done in reset", {{(N*DW-1){1'b0}}, resDone}, 0);
    chk("R1 data in reset", resData, '0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 data after reset", resData, '0);
    chk("R1 done after reset", {{(N*DW-1){1'b0}}, resDone}, 0);

    for (int i = 0; i < N; i++) d[i*DW +: DW] = DW'(16'h1000 + i);
    // R3 xor-4 pattern
    for (int i = 0; i < N; i++) ix[i*IW +: IW] = IW'(4);
    runCmd(2'd1, 2'd0, d, ix, 1'b0);
    // R2 reversal with wrapped indices (idx+8)
    for (int i = 0; i < N; i++) ix[i*IW +: IW] = IW'(8 + (N - 1 - i));
    runCmd(2'd0, 2'd0, d, ix, 1'b0);
    // R4 broadcast from lane 5 via wrapped index 13
    ix = '0; ix[IW-1:0] = IW'(13); ix[IW +: IW] = IW'(2);
    runCmd(2'd2, 2'd0, d, ix, 1'b0);
    // R6 sum overflow
    d = '1;
    runCmd(2'd3, 2'd0, d, '0, 1'b1);
    runCmd(2'd3, 2'd3, d, '0, 1'b0);
    // R7 max
    for (int i = 0; i < N; i++) d[i*DW +: DW] = DW'(i * 3);
    d[5*DW +: DW] = 16'hFFFF;
    runCmd(2'd3, 2'd1, d, '0, 1'b0);
    // R8 logical AND with one zero lane, then all nonzero
    runCmd(2'd3, 2'd2, d, '0, 1'b1);
    d[0 +: DW] = 16'h0100;
    runCmd(2'd3, 2'd2, d, '0, 1'b0);

    for (int n = 0; n < 300; n++) begin
      logic [1:0] op;
      logic [1:0] sel;
      op = 2'($urandom % 4);
      sel = 2'($urandom % 4);
      for (int i = 0; i < N; i++) begin
        if ((sel == 2'd2) && (($urandom % 6) == 0)) d[i*DW +: DW] = '0;
        else d[i*DW +: DW] = DW'($urandom);
      end
      for (int i = 0; i < N; i++) ix[i*IW +: IW] = IW'($urandom);
      runCmd(op, sel, d, ix, bit'($urandom % 2));
      if (($urandom % 3) == 0) begin
        @(negedge clk);
        chk("R11 idle no done", {{(N*DW-1){1'b0}}, resDone}, 0);
      end
    end
    report();
  end

endmodule